// File: doc/BRIEF.md
# Serial Link Rate Change Sequencer

This block takes a request to move a serial transmit link to a new bit rate and carries it out against the transceiver's PLL and power controls. A single start pulse captures a rate code in Mb/s, an active lane count, and a 2-bit drive swing and 2-bit pre-emphasis level for each lane. The captured request first passes a legality check. A request that fails is refused with an error flag, and nothing else at the outputs moves.

A legal request runs a fixed handshaked sequence. The active lanes are parked in the deepest power state, and the per-lane PLL clock enables are dropped. The raw PLL enable is then cleared, and the block waits for the PLL to report it is off. The new rate is passed to the VCO configuration logic, and the PLL is turned back on and must report ready. After that the lane clock enables return, and the lanes climb back to full power in two steps. Fixed gaps separate the steps. Every wait on the transceiver is bounded by a timeout that ends the run in the error state.

At the default 250 MHz clock the gaps are 25, 50 and 225 cycles (100 ns, 200 ns and 900 ns). All three lengths and the timeout are parameters.

Top module: `lrate_seq`

## Requirements
- R1: Only the rate codes 1620, 2160, 2430, 2700, 3240, 4320, 5400 and 8100 are accepted. Any other value of `reqRate` raises `err` and leaves `done` low.
- R2: The lane count must be 1, 2 or 4 and must not exceed `NUM_LANES`. Any other count raises `err`.
- R3: For each enabled lane i (i < lane count), the swing (`reqSwing[2i+1:2i]`) plus the pre-emphasis (`reqPreEmph[2i+1:2i]`) must not exceed 3, or the request is refused. Values on lanes at or above the lane count are ignored.
- R4: A refused request leaves `pstateReq`, `pllClkEn`, `pllRawCtrl` and `vcoRate` unchanged and never raises `done`. `done` and `err` are never high together.
- R5: A legal run first requests state A3. Once `pstateAck` equals the request, it drives `pllClkEn` to zero in the next cycle. It then waits until `pllClkEnAck` under the lane mask reads zero.
- R6: After the off-acknowledge and a 25-cycle gap, `pllRawCtrl` goes to 0. After `pllOff` is seen and a further 50-cycle gap, `vcoRate` takes the new rate, and only while `pllRawCtrl` is 0. The raw control returns to 3 exactly `dPll`+52 cycles after it went to 0, where `dPll` is the `pllOff` latency.
- R7: After `pllReady` is seen and a 50-cycle gap, `pllClkEn` is set to the lane mask: 0x1 for one lane, 0x3 for two and 0xF for four. This happens `dPll`+51 cycles after the raw control returned to 3.
- R8: Power state A2 is requested, and then A0. Once A0 is acknowledged, `done` rises after a 225-cycle gap, exactly 226+`dPs` cycles after the A0 request. `dPs` is the acknowledge latency.
- R9: Each clock-enable acknowledge is followed by a 25-cycle gap. The A2 request comes 26+`dClk` cycles after the enables return, and the raw-off 27+`dPs`+`dClk` cycles after the A3 request.
- R10: A handshake wait that sees no acknowledge within `TIMEOUT_CYC` cycles ends in `err`, and every output then holds. An acknowledge that arrives in the last allowed cycle is accepted.
- R11: Reset leaves `pstateReq` = A0, `pllClkEn` all ones, `pllRawCtrl` = 3, `vcoRate` = `INIT_RATE`, and `done` and `err` low.
- R12: `pstateReq` is one-hot, with bit 0 = A0, bit 1 = A1, bit 2 = A2 and bit 3 = A3.
- R13: A start pulse that arrives while a run is in progress is ignored, and the run completes with the rate captured first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture request and begin |
| reqRate | input | RATE_W | Requested rate in Mb/s |
| reqLanes | input | LCNT_W | Requested active lane count |
| reqSwing | input | 2*NUM_LANES | Per-lane swing level |
| reqPreEmph | input | 2*NUM_LANES | Per-lane pre-emphasis level |
| pstateReq | output | 4 | One-hot power-state request |
| pstateAck | input | 4 | Power state reported by lanes |
| pllClkEn | output | NUM_LANES | Per-lane PLL clock enable |
| pllClkEnAck | input | NUM_LANES | Per-lane clock enable acknowledge |
| pllRawCtrl | output | 2 | Raw PLL enable (0 off, 3 on) |
| pllReady | input | 1 | PLL locked and ready |
| pllOff | input | 1 | PLL de-asserted |
| vcoRate | output | RATE_W | Rate code for VCO setup |
| done | output | 1 | Last run completed |
| err | output | 1 | Last run refused or timed out |

## Verification
The timeout counter and an acknowledge can land in the same cycle. The design must accept the acknowledge on the final permitted cycle and give up one cycle later. The bench's responder delays the power-state acknowledge by exactly `TIMEOUT_CYC`-1 cycles in one run and by `TIMEOUT_CYC` cycles in the next. The first run must end with `done` and with A0 reached 226+`TIMEOUT_CYC`-1 cycles after its request. The second must end with `err` and the outputs frozen at the A3 request.

// File: rtl/lrate_pkg.sv
package lrate_pkg;

  localparam logic [3:0] PS_A0 = 4'b0001;
  localparam logic [3:0] PS_A1 = 4'b0010;
  localparam logic [3:0] PS_A2 = 4'b0100;
  localparam logic [3:0] PS_A3 = 4'b1000;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_PWR_DN, ST_CLK_OFF, ST_GAP_A, ST_RAW_OFF,
    ST_GAP_B, ST_PROG, ST_RAW_ON, ST_GAP_C, ST_CLK_ON, ST_GAP_D,
    ST_PWR_MID, ST_PWR_UP, ST_GAP_E
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic latch;
    logic clrCnt;
    logic reqA3;
    logic reqA2;
    logic reqA0;
    logic clkOff;
    logic clkOn;
    logic rawOff;
    logic rawOn;
    logic loadRate;
    logic setDone;
    logic setErr;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic legal;
    logic psAcked;
    logic clkOffSeen;
    logic clkOnSeen;
    logic pllDown;
    logic pllUp;
    logic gapShort;
    logic gapMid;
    logic gapLong;
    logic timeout;
  } seqCond_t;

endpackage

// File: rtl/lrate_ctrl.sv
module lrate_ctrl
  import lrate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqCond_t   cond,
  output seqStrobe_t stb
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: if (start) begin stb.latch = 1'b1; stateNext = ST_CHECK; end
      ST_CHECK:
        if (cond.legal) begin
          stb.reqA3 = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_PWR_DN;
        end else begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_PWR_DN:
        if (cond.psAcked) begin
          stb.clkOff = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_CLK_OFF;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_CLK_OFF:
        if (cond.clkOffSeen) begin
          stb.clrCnt = 1'b1; stateNext = ST_GAP_A;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_GAP_A:
        if (cond.gapShort) begin
          stb.rawOff = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_RAW_OFF;
        end
      ST_RAW_OFF:
        if (cond.pllDown) begin
          stb.clrCnt = 1'b1; stateNext = ST_GAP_B;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_GAP_B:
        if (cond.gapMid) begin stb.loadRate = 1'b1; stateNext = ST_PROG; end
      ST_PROG: begin
        stb.rawOn = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_RAW_ON;
      end
      ST_RAW_ON:
        if (cond.pllUp) begin
          stb.clrCnt = 1'b1; stateNext = ST_GAP_C;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_GAP_C:
        if (cond.gapMid) begin
          stb.clkOn = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_CLK_ON;
        end
      ST_CLK_ON:
        if (cond.clkOnSeen) begin
          stb.clrCnt = 1'b1; stateNext = ST_GAP_D;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_GAP_D:
        if (cond.gapShort) begin
          stb.reqA2 = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_PWR_MID;
        end
      ST_PWR_MID:
        if (cond.psAcked) begin
          stb.reqA0 = 1'b1; stb.clrCnt = 1'b1; stateNext = ST_PWR_UP;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_PWR_UP:
        if (cond.psAcked) begin
          stb.clrCnt = 1'b1; stateNext = ST_GAP_E;
        end else if (cond.timeout) begin
          stb.setErr = 1'b1; stateNext = ST_IDLE;
        end
      ST_GAP_E:
        if (cond.gapLong) begin stb.setDone = 1'b1; stateNext = ST_IDLE; end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lrate_dp.sv
module lrate_dp
  import lrate_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int RATE_W      = 14,
  parameter int LCNT_W      = 4,
  parameter int GAP_SHORT   = 25,
  parameter int GAP_MID     = 50,
  parameter int GAP_LONG    = 225,
  parameter int TIMEOUT_CYC = 4000,
  parameter int INIT_RATE   = 1620
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             stb,
  input  logic [RATE_W-1:0]      reqRate,
  input  logic [LCNT_W-1:0]      reqLanes,
  input  logic [2*NUM_LANES-1:0] reqSwing,
  input  logic [2*NUM_LANES-1:0] reqPreEmph,
  input  logic [3:0]             pstateAck,
  input  logic [NUM_LANES-1:0]   pllClkEnAck,
  input  logic                   pllReady,
  input  logic                   pllOff,
  output seqCond_t               cond,
  output logic [3:0]             pstateReq,
  output logic [NUM_LANES-1:0]   pllClkEn,
  output logic [1:0]             pllRawCtrl,
  output logic [RATE_W-1:0]      vcoRate,
  output logic                   done,
  output logic                   err
);

  localparam int MAX_GAP = (GAP_LONG > GAP_MID) ? GAP_LONG : GAP_MID;
  localparam int MAX_CNT = (TIMEOUT_CYC > MAX_GAP) ? TIMEOUT_CYC : MAX_GAP;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [RATE_W-1:0]      rateQ;
  logic [LCNT_W-1:0]      lanesQ;
  logic [2*NUM_LANES-1:0] swingQ, preQ;
  logic [CNT_W-1:0]       cnt;
  logic [NUM_LANES-1:0]   laneMask, laneOk;
  logic                   rateOk, lanesOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= '0; lanesQ <= '0; swingQ <= '0; preQ <= '0;
    end else if (stb.latch) begin
      rateQ <= reqRate; lanesQ <= reqLanes; swingQ <= reqSwing; preQ <= reqPreEmph;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clrCnt) cnt <= '0;
    else if (cnt != CNT_W'(MAX_CNT)) cnt <= cnt + 1'b1;
  end

  // legality and lane mask
  always_comb begin
    unique case (rateQ)
      RATE_W'(1620), RATE_W'(2160), RATE_W'(2430), RATE_W'(2700),
      RATE_W'(3240), RATE_W'(4320), RATE_W'(5400), RATE_W'(8100): rateOk = 1'b1;
      default: rateOk = 1'b0;
    endcase
    lanesOk = (lanesQ == LCNT_W'(1) || lanesQ == LCNT_W'(2) || lanesQ == LCNT_W'(4))
              && (lanesQ <= LCNT_W'(NUM_LANES));
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [2:0] levelSum;
    assign levelSum    = {1'b0, swingQ[2*i +: 2]} + {1'b0, preQ[2*i +: 2]};
    assign laneMask[i] = LCNT_W'(i) < lanesQ;
    assign laneOk[i]   = !laneMask[i] || (levelSum <= 3'd3);
  end

  always_comb begin
    cond.legal      = rateOk && lanesOk && (&laneOk);
    cond.psAcked    = (pstateAck == pstateReq);
    cond.clkOffSeen = (pllClkEnAck & laneMask) == '0;
    cond.clkOnSeen  = (pllClkEnAck & laneMask) == laneMask;
    cond.pllDown    = pllOff;
    cond.pllUp      = pllReady;
    cond.gapShort   = cnt == CNT_W'(GAP_SHORT - 1);
    cond.gapMid     = cnt == CNT_W'(GAP_MID - 1);
    cond.gapLong    = cnt == CNT_W'(GAP_LONG - 1);
    cond.timeout    = cnt >= CNT_W'(TIMEOUT_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pstateReq  <= PS_A0;
      pllClkEn   <= '1;
      pllRawCtrl <= 2'b11;
      vcoRate    <= RATE_W'(INIT_RATE);
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      if (stb.reqA3)         pstateReq <= PS_A3;
      else if (stb.reqA2)    pstateReq <= PS_A2;
      else if (stb.reqA0)    pstateReq <= PS_A0;
      if (stb.clkOff)        pllClkEn  <= '0;
      else if (stb.clkOn)    pllClkEn  <= laneMask;
      if (stb.rawOff)        pllRawCtrl <= 2'b00;
      else if (stb.rawOn)    pllRawCtrl <= 2'b11;
      if (stb.loadRate)      vcoRate <= rateQ;
      if (stb.latch) begin
        done <= 1'b0; err <= 1'b0;
      end else begin
        if (stb.setDone) done <= 1'b1;
        if (stb.setErr)  err  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lrate_seq.sv
module lrate_seq
  import lrate_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int RATE_W      = 14,
  parameter int LCNT_W      = 4,
  parameter int GAP_SHORT   = 25,
  parameter int GAP_MID     = 50,
  parameter int GAP_LONG    = 225,
  parameter int TIMEOUT_CYC = 4000,
  parameter int INIT_RATE   = 1620
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [RATE_W-1:0]      reqRate,
  input  logic [LCNT_W-1:0]      reqLanes,
  input  logic [2*NUM_LANES-1:0] reqSwing,
  input  logic [2*NUM_LANES-1:0] reqPreEmph,
  output logic [3:0]             pstateReq,
  input  logic [3:0]             pstateAck,
  output logic [NUM_LANES-1:0]   pllClkEn,
  input  logic [NUM_LANES-1:0]   pllClkEnAck,
  output logic [1:0]             pllRawCtrl,
  input  logic                   pllReady,
  input  logic                   pllOff,
  output logic [RATE_W-1:0]      vcoRate,
  output logic                   done,
  output logic                   err
);

  seqStrobe_t stb;
  seqCond_t   cond;

  lrate_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .cond(cond), .stb(stb)
  );

  lrate_dp #(
    .NUM_LANES(NUM_LANES), .RATE_W(RATE_W), .LCNT_W(LCNT_W),
    .GAP_SHORT(GAP_SHORT), .GAP_MID(GAP_MID), .GAP_LONG(GAP_LONG),
    .TIMEOUT_CYC(TIMEOUT_CYC), .INIT_RATE(INIT_RATE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqRate(reqRate), .reqLanes(reqLanes), .reqSwing(reqSwing), .reqPreEmph(reqPreEmph),
    .pstateAck(pstateAck), .pllClkEnAck(pllClkEnAck), .pllReady(pllReady), .pllOff(pllOff),
    .cond(cond), .pstateReq(pstateReq), .pllClkEn(pllClkEn), .pllRawCtrl(pllRawCtrl),
    .vcoRate(vcoRate), .done(done), .err(err)
  );

endmodule

// File: rtl/lrate_seq_chk.sv
module lrate_seq_chk #(
  parameter int NUM_LANES = 4,
  parameter int RATE_W    = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic [3:0]           pstateReq,
  input logic [NUM_LANES-1:0] pllClkEn,
  input logic [1:0]           pllRawCtrl,
  input logic [RATE_W-1:0]    vcoRate,
  input logic                 done,
  input logic                 err
);

  // R12
  pstate_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(pstateReq));

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  // R10
  err_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> (err && $stable(pstateReq) && $stable(pllClkEn)
                         && $stable(pllRawCtrl) && $stable(vcoRate)));

  // R6
  rate_while_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vcoRate) |-> (pllRawCtrl == 2'b00));

  // R5
  raw_off_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pllRawCtrl == 2'b00 && $past(pllRawCtrl) == 2'b11)
      |-> (pllClkEn == '0 && pstateReq == 4'b1000));

  // R7
  clk_back_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pllClkEn != '0 && $past(pllClkEn) == '0) |-> (pllRawCtrl == 2'b11));

  // R8
  done_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (pstateReq == 4'b0001 && pllRawCtrl == 2'b11));

endmodule

bind lrate_seq lrate_seq_chk #(.NUM_LANES(NUM_LANES), .RATE_W(RATE_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .pstateReq(pstateReq),
  .pllClkEn(pllClkEn), .pllRawCtrl(pllRawCtrl), .vcoRate(vcoRate),
  .done(done), .err(err)
);

// File: tb/lrate_seq_tb.sv
module lrate_seq_tb_top;

  localparam int NL  = 4;
  localparam int RW  = 14;
  localparam int LW  = 4;
  localparam int TO  = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] reqRate = '0;
  logic [LW-1:0] reqLanes = '0;
  logic [7:0]    reqSwing = '0, reqPreEmph = '0;
  logic [3:0]    pstateReq, pstateAck;
  logic [NL-1:0] pllClkEn, pllClkEnAck;
  logic [1:0]    pllRawCtrl;
  logic          pllReady, pllOff;
  logic [RW-1:0] vcoRate;
  logic          done, err;

  int nChk = 0, nFail = 0, totCyc = 0;
  int dPs = 0, dClk = 0, dPll = 0;

  always #2 clk = ~clk;

  lrate_seq #(.NUM_LANES(NL), .RATE_W(RW), .LCNT_W(LW), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .reqRate(reqRate), .reqLanes(reqLanes),
    .reqSwing(reqSwing), .reqPreEmph(reqPreEmph), .pstateReq(pstateReq),
    .pstateAck(pstateAck), .pllClkEn(pllClkEn), .pllClkEnAck(pllClkEnAck),
    .pllRawCtrl(pllRawCtrl), .pllReady(pllReady), .pllOff(pllOff),
    .vcoRate(vcoRate), .done(done), .err(err)
  );

  // behavioural transceiver responder with programmable latencies
  logic [3:0]    psSeen;
  logic [NL-1:0] enSeen;
  logic [1:0]    rawSeen;
  int psAge, enAge, rawAge;

  always @(negedge clk) begin
    totCyc++;
    if (!rstN) begin
      psSeen = 4'b0001; pstateAck = 4'b0001;
      enSeen = '1; pllClkEnAck = '1;
      rawSeen = 2'b11; pllReady = 1'b1; pllOff = 1'b0;
      psAge = 0; enAge = 0; rawAge = 0;
    end else begin
      if (pstateReq != psSeen) begin psSeen = pstateReq; psAge = 0; end
      else if (psAge < 100000) psAge++;
      if (pllClkEn != enSeen) begin enSeen = pllClkEn; enAge = 0; end
      else if (enAge < 100000) enAge++;
      if (pllRawCtrl != rawSeen) begin rawSeen = pllRawCtrl; rawAge = 0; end
      else if (rawAge < 100000) rawAge++;
      if (psAge >= dPs) pstateAck = psSeen;
      if (enAge >= dClk) pllClkEnAck = enSeen;
      if (rawAge >= dPll) begin
        pllReady = (rawSeen == 2'b11);
        pllOff   = (rawSeen == 2'b00);
      end
    end
  end

  function automatic bit rateOk(int r);
    return r == 1620 || r == 2160 || r == 2430 || r == 2700 ||
           r == 3240 || r == 4320 || r == 5400 || r == 8100;
  endfunction

  function automatic bit lanesOk(int l);
    return (l == 1 || l == 2 || l == 4) && l <= NL;
  endfunction

  function automatic bit voltOk(int l, logic [7:0] sw, logic [7:0] pr);
    for (int i = 0; i < NL; i++)
      if (i < l && (int'(sw[2*i +: 2]) + int'(pr[2*i +: 2]) > 3)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NL-1:0] maskOf(int l);
    return NL'((1 << l) - 1);
  endfunction

  function automatic int legalRate(int idx);
    case (idx)
      0: return 1620; 1: return 2160; 2: return 2430; 3: return 2700;
      4: return 3240; 5: return 4320; 6: return 5400; default: return 8100;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  task automatic runSeq(input int rate, input int lanes, input logic [7:0] sw,
                        input logic [7:0] pr, input bit poke);
    logic [3:0]    sPs  = pstateReq;
    logic [NL-1:0] sEn  = pllClkEn;
    logic [1:0]    sRaw = pllRawCtrl;
    logic [RW-1:0] sVco = vcoRate;
    bit clean = (sPs == 4'b0001) && (sRaw == 2'b11) && (sEn != '0);
    bit legal = rateOk(rate) && lanesOk(lanes) && voltOk(lanes, sw, pr);
    int toStage = (dPs >= TO) ? 1 : (dClk >= TO) ? 2 : (dPll >= TO) ? 3 : 0;
    int tA3 = -1, tEn0 = -1, tRaw0 = -1, tRaw3 = -1, tEn = -1, tA2 = -1, tA0 = -1, tEnd = -1;
    @(negedge clk);
    reqRate = RW'(rate); reqLanes = LW'(lanes); reqSwing = sw; reqPreEmph = pr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 1; cyc < 4000; cyc++) begin
      if (poke && cyc == 6) begin start = 1'b1; reqRate = RW'(legalRate(0)); end
      if (poke && cyc == 7) start = 1'b0;
      if (tA3 < 0 && pstateReq == 4'b1000) tA3 = cyc;
      if (tA3 >= 0 && tEn0 < 0 && pllClkEn == '0) tEn0 = cyc;
      if (tRaw0 < 0 && pllRawCtrl == 2'b00) tRaw0 = cyc;
      if (tRaw0 >= 0 && tRaw3 < 0 && pllRawCtrl == 2'b11) tRaw3 = cyc;
      if (tRaw3 >= 0 && tEn < 0 && pllClkEn != '0) tEn = cyc;
      if (tA2 < 0 && pstateReq == 4'b0100) tA2 = cyc;
      if (tA2 >= 0 && tA0 < 0 && pstateReq == 4'b0001) tA0 = cyc;
      if (done || err) begin tEnd = cyc; break; end
      @(negedge clk);
    end
    chk(tEnd >= 0, "R10", "run finished", tEnd, 1);
    if (tEnd < 0) return;
    if (!legal) begin
      // R1 R2 R3 R4: refused, nothing moved
      chk(err && !done, "R4", "refusal err", err, 1);
      chk(pstateReq == sPs && pllClkEn == sEn && pllRawCtrl == sRaw && vcoRate == sVco,
          "R4", "outputs unchanged", {pstateReq, pllClkEn, pllRawCtrl}, {sPs, sEn, sRaw});
    end else if (toStage != 0) begin
      chk(err && !done, "R10", "timeout err", err, 1);
      chk(pstateReq == 4'b1000, "R10", "pstate frozen", pstateReq, 8);
      chk(pllClkEn == ((toStage == 1) ? sEn : '0), "R10", "clk en frozen", pllClkEn,
          (toStage == 1) ? sEn : 0);
      chk(pllRawCtrl == ((toStage == 3) ? 2'b00 : sRaw), "R10", "raw frozen", pllRawCtrl,
          (toStage == 3) ? 0 : sRaw);
      chk(vcoRate == sVco, "R10", "rate untouched", vcoRate, sVco);
      repeat (5) @(negedge clk);
      chk(err && pstateReq == 4'b1000 && vcoRate == sVco, "R10", "still frozen", err, 1);
    end else begin
      chk(done && !err, "R1", "accepted run done", {done, err}, 2);
      chk(vcoRate == RW'(rate), "R6", "new rate", vcoRate, rate);
      chk(pllClkEn == maskOf(lanes), "R7", "lane mask", pllClkEn, maskOf(lanes));
      chk(pstateReq == 4'b0001 && pllRawCtrl == 2'b11, "R8", "final state",
          {pstateReq, pllRawCtrl}, 7);
      if (clean) begin
        chk(tEn0 - tA3 == dPs + 1, "R5", "clk off after A3 ack", tEn0 - tA3, dPs + 1);
        chk(tRaw0 - tA3 == dPs + dClk + 27, "R9", "raw off gap", tRaw0 - tA3, dPs + dClk + 27);
        chk(tRaw3 - tRaw0 == dPll + 52, "R6", "reprogram gap", tRaw3 - tRaw0, dPll + 52);
        chk(tEn - tRaw3 == dPll + 51, "R7", "enable after lock", tEn - tRaw3, dPll + 51);
        chk(tA2 - tEn == dClk + 26, "R9", "A2 after enable", tA2 - tEn, dClk + 26);
        chk(tEnd - tA0 == dPs + 226, "R8", "final gap", tEnd - tA0, dPs + 226);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11
    chk(pstateReq == 4'b0001, "R11", "reset pstate", pstateReq, 1);
    chk(pllClkEn == '1 && pllRawCtrl == 2'b11, "R11", "reset pll", {pllClkEn, pllRawCtrl}, 63);
    chk(vcoRate == RW'(1620) && !done && !err, "R11", "reset rate/flags", vcoRate, 1620);

    runSeq(8100, 4, 8'h00, 8'h00, 0);                 // R1 R7 mask 0xF
    runSeq(2700, 1, 8'h03, 8'h00, 0);                 // R7 mask 0x1
    dPs = 3; dClk = 2; dPll = 5;
    runSeq(5400, 2, 8'h09, 8'h06, 0);                 // R7 mask 0x3, R3 sums 3
    runSeq(2160, 1, 8'hFC, 8'hFC, 0);                 // R3 lanes 1..3 ignored
    runSeq(4320, 2, 8'h0C, 8'h04, 0);                 // R3 lane1 sum 4 refused
    runSeq(3240, 3, 8'h00, 8'h00, 0);                 // R2 three lanes refused
    runSeq(3240, 5, 8'h00, 8'h00, 0);                 // R2 above NUM_LANES
    runSeq(3240, 0, 8'h00, 8'h00, 0);                 // R2 zero lanes
    runSeq(1621, 4, 8'h00, 8'h00, 0);                 // R1 near-miss code
    runSeq(2430, 4, 8'h00, 8'h00, 1);                 // R13 start while busy
    dPs = TO - 1; dClk = 0; dPll = 0;
    runSeq(1620, 4, 8'h00, 8'h00, 0);                 // R10 ack on last cycle
    dPs = TO;
    runSeq(2700, 4, 8'h00, 8'h00, 0);                 // R10 ack one cycle late
    dPs = 0;
    runSeq(5400, 4, 8'h00, 8'h00, 0);                 // recovery
    dPll = TO;
    runSeq(8100, 2, 8'h00, 8'h00, 0);                 // R10 PLL never down
    dPll = 0;
    runSeq(2160, 4, 8'h00, 8'h00, 0);                 // recovery

    for (int n = 0; n < 60; n++) begin
      int r = ($urandom % 4 != 0) ? legalRate($urandom % 8) : int'($urandom % 16384);
      int l = $urandom % 6;
      logic [7:0] sw = '0, pr = '0;
      for (int i = 0; i < NL; i++) begin
        int s = $urandom % 4;
        sw[2*i +: 2] = 2'(s);
        pr[2*i +: 2] = ($urandom % 5 == 0) ? 2'($urandom % 4) : 2'($urandom % (4 - s));
      end
      dPs = $urandom % 12; dClk = $urandom % 12; dPll = $urandom % 12;
      runSeq(r, l, sw, pr, 0);
    end
    finish();
  end

  initial begin
    wait (totCyc > 150000);
    nChk++; nFail++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", totCyc, 150000);
    finish();
  end

endmodule